// File: doc/BRIEF.md
# Cartridge Bank-Switching Controller

This block watches CPU writes that land in the lower half of a 64 KiB address space (the cartridge ROM window, addresses with bit 15 clear) and treats each one as a command rather than a store. Depending on which 4 KiB or 8 KiB slice of that window is written, and on which of three controller flavours is selected, the data byte changes the switchable ROM bank number, the external RAM bank number, the external RAM enable flag, or a select that steers external RAM accesses onto a set of clock registers.

The flavour and the two bank-count inputs are set before reset is released and held afterwards. Every accepted command updates the registered outputs on the clock edge that samples it. The stored bank numbers are then trimmed to the number of banks actually fitted. Downstream address logic uses the outputs directly to form physical ROM and RAM addresses.

Top module: `cart_bank_ctrl`

## Requirements
- R1: For flavours 0, 1 and 2, a write to 0x0000–0x1FFF sets `ram_en` when wr_data[3:0] is 0xA and clears it for any other low nibble.
- R2: Flavour 0 (`ctrl_type`=0), write to 0x2000–0x3FFF: ROM bank bits 4:0 take wr_data[4:0], with 0 replaced by 1. Bits 6:5 keep their value and bits 8:7 become 0.
- R3: Flavour 0, write to 0x4000–0x5FFF: when the internal mode bit is 1, the RAM bank becomes wr_data[1:0] and the ROM bank is unchanged. When the mode bit is 0, ROM bank bits 6:5 become wr_data[1:0] and the RAM bank is unchanged.
- R4: Flavour 0, write to 0x6000–0x7FFF: the mode bit becomes wr_data[0]. The mode bit is 0 after reset.
- R5: Flavour 1 (`ctrl_type`=1), write to 0x2000–0x3FFF: the ROM bank becomes wr_data[6:0], with 0 replaced by 1.
- R6: Flavour 1, write to 0x4000–0x5FFF: the 4-bit clock select becomes wr_data[3:0], driving `clk_reg_sel`=wr_data[2:0] and `clk_reg_vld`=wr_data[3]. In the same write, the RAM bank becomes wr_data[1:0].
- R7: Flavour 2 (`ctrl_type`=2): a write to 0x2000–0x2FFF sets ROM bank bits 7:0 to wr_data (0 replaced by 1). A write to 0x3000–0x3FFF sets ROM bank bit 8 to wr_data[0]. A write to 0x4000–0x5FFF sets the RAM bank to wr_data[3:0].
- R8: After every accepted write, the ROM bank is ANDed with (`rom_size`−1) and the RAM bank with (`ram_size`−1). The outputs change on the rising clock edge that samples `wr_en`.
- R9: While reset is asserted, and until the first accepted write, the outputs are `rom_bank`=1, `ram_bank`=0, `ram_en`=0, `clk_reg_sel`=0 and `clk_reg_vld`=0.
- R10: Some writes leave every output unchanged: writes with wr_addr[15]=1, cycles with `wr_en`=0, and any write with `ctrl_type`=3. Writes to 0x6000–0x7FFF under flavours 1 and 2 change nothing except the trimming of R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctrl_type | input | 2 | Controller flavour: 0, 1, 2; 3 ignores all writes |
| rom_size | input | 10 | Number of ROM banks fitted, a power of two (1 to 512) |
| ram_size | input | 5 | Number of RAM banks fitted, a power of two (1 to 16) |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| rom_bank | output | 9 | Current switchable ROM bank |
| ram_bank | output | 4 | Current external RAM bank |
| ram_en | output | 1 | External RAM enabled |
| clk_reg_sel | output | 3 | Clock register index |
| clk_reg_vld | output | 1 | External RAM accesses go to clock registers |

## Verification
Two functions can act on the same write. The zero-to-one replacement of the ROM bank number coincides with the size trimming, and a flavour-1 write to 0x4000 loads the clock select and the RAM bank together. The bench provokes the first case by writing zero data with `rom_size`=1, where the expected bank is 0 (replacement first, then the mask), and with larger sizes, where it is 1. For the second case it writes values whose bit 3 and low two bits differ under a small `ram_size`, and judges both fields against a bench model after the same edge. Random writes across all flavours and sizes recreate both overlaps many times more.

// File: rtl/bank_pkg.sv
package bank_pkg;

  typedef enum logic [1:0] {
    CT_TYPEA = 2'd0,
    CT_SEVEN = 2'd1,
    CT_NINE  = 2'd2,
    CT_NONE  = 2'd3
  } ctl_kind_e;

  typedef enum logic [2:0] {
    RG_EN    = 3'd0,
    RG_ROM_A = 3'd1,
    RG_ROM_B = 3'd2,
    RG_AUX   = 3'd3,
    RG_MODE  = 3'd4
  } region_e;

endpackage

// File: rtl/bank_rst_sync.sv
module bank_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/bank_size_mask.sv
module bank_size_mask #(
  parameter int W = 9
) (
  input  logic [W:0]   size_i,
  output logic [W-1:0] mask_o
);

  logic [W:0] size_m1;

  assign size_m1 = size_i - {{W{1'b0}}, 1'b1};
  assign mask_o  = size_m1[W-1:0];

  logic unused_top_bit;
  assign unused_top_bit = size_m1[W];

endmodule

// File: rtl/bank_region_dec.sv
module bank_region_dec
  import bank_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output region_e           region
);

  localparam int SEL_LSB = ADDR_W - 4;

  logic [2:0] slice;

  assign slice = addr[SEL_LSB +: 3];
  assign hit   = wr_en && !addr[ADDR_W-1];

  always_comb begin
    case (slice)
      3'd0, 3'd1: region = RG_EN;
      3'd2:       region = RG_ROM_A;
      3'd3:       region = RG_ROM_B;
      3'd4, 3'd5: region = RG_AUX;
      default:    region = RG_MODE;
    endcase
  end

  logic unused_low_addr;
  assign unused_low_addr = ^addr[SEL_LSB-1:0];

endmodule

// File: rtl/bank_cmd_decode.sv
module bank_cmd_decode
  import bank_pkg::*;
#(
  parameter int ROM_W  = 9,
  parameter int RAM_W  = 4,
  parameter int DATA_W = 8,
  parameter int CSEL_W = 4
) (
  input  ctl_kind_e         kind,
  input  region_e           region,
  input  logic [DATA_W-1:0] data,
  input  logic [ROM_W-1:0]  rom_q,
  input  logic [RAM_W-1:0]  ram_q,
  input  logic              en_q,
  input  logic              mode_q,
  input  logic [CSEL_W-1:0] sel_q,
  output logic [ROM_W-1:0]  rom_n,
  output logic [RAM_W-1:0]  ram_n,
  output logic              en_n,
  output logic              mode_n,
  output logic [CSEL_W-1:0] sel_n
);

  logic [4:0] lo5;
  logic [6:0] lo7;
  logic [7:0] lo8;
  logic       en_cmd;

  assign lo5    = (data[4:0] == 5'd0) ? 5'd1 : data[4:0];
  assign lo7    = (data[6:0] == 7'd0) ? 7'd1 : data[6:0];
  assign lo8    = (data[7:0] == 8'd0) ? 8'd1 : data[7:0];
  assign en_cmd = (data[3:0] == 4'hA);

  always_comb begin
    rom_n  = rom_q;
    ram_n  = ram_q;
    en_n   = en_q;
    mode_n = mode_q;
    sel_n  = sel_q;
    case (kind)
      CT_TYPEA: begin
        case (region)
          RG_EN: en_n = en_cmd;
          RG_ROM_A, RG_ROM_B: begin
            rom_n      = '0;
            rom_n[6:5] = rom_q[6:5];
            rom_n[4:0] = lo5;
          end
          RG_AUX: begin
            if (mode_q) begin
              ram_n      = '0;
              ram_n[1:0] = data[1:0];
            end else begin
              rom_n      = '0;
              rom_n[6:5] = data[1:0];
              rom_n[4:0] = rom_q[4:0];
            end
          end
          default: mode_n = data[0];
        endcase
      end
      CT_SEVEN: begin
        case (region)
          RG_EN: en_n = en_cmd;
          RG_ROM_A, RG_ROM_B: begin
            rom_n      = '0;
            rom_n[6:0] = lo7;
          end
          RG_AUX: begin
            sel_n      = data[CSEL_W-1:0];
            ram_n      = '0;
            ram_n[1:0] = data[1:0];
          end
          default: ;
        endcase
      end
      CT_NINE: begin
        case (region)
          RG_EN:    en_n = en_cmd;
          RG_ROM_A: rom_n[7:0] = lo8;
          RG_ROM_B: rom_n[8]   = data[0];
          RG_AUX: begin
            ram_n      = '0;
            ram_n[3:0] = data[3:0];
          end
          default: ;
        endcase
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import bank_pkg::*;
#(
  parameter int ROM_W  = 9,
  parameter int RAM_W  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CSEL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        ctrl_type,
  input  logic [ROM_W:0]    rom_size,
  input  logic [RAM_W:0]    ram_size,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [ROM_W-1:0]  rom_bank,
  output logic [RAM_W-1:0]  ram_bank,
  output logic              ram_en,
  output logic [CSEL_W-2:0] clk_reg_sel,
  output logic              clk_reg_vld
);

  localparam logic [ROM_W-1:0] ROM_RST = ROM_W'(1);

  logic       rst_sync_n;
  logic       hit;
  logic       upd;
  region_e    region;
  ctl_kind_e  kind;

  logic [ROM_W-1:0]  rom_mask, rom_q, rom_n, rom_d;
  logic [RAM_W-1:0]  ram_mask, ram_q, ram_n, ram_d;
  logic              en_q, en_n, mode_q, mode_n;
  logic [CSEL_W-1:0] sel_q, sel_n;

  bank_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_sync_n)
  );

  bank_size_mask #(.W(ROM_W)) u_rom_mask (.size_i(rom_size), .mask_o(rom_mask));
  bank_size_mask #(.W(RAM_W)) u_ram_mask (.size_i(ram_size), .mask_o(ram_mask));

  bank_region_dec #(.ADDR_W(ADDR_W)) u_dec (
    .wr_en(wr_en), .addr(wr_addr), .hit(hit), .region(region)
  );

  assign kind = ctl_kind_e'(ctrl_type);
  assign upd  = hit && (kind != CT_NONE);

  bank_cmd_decode #(
    .ROM_W(ROM_W), .RAM_W(RAM_W), .DATA_W(DATA_W), .CSEL_W(CSEL_W)
  ) u_cmd (
    .kind(kind), .region(region), .data(wr_data),
    .rom_q(rom_q), .ram_q(ram_q), .en_q(en_q), .mode_q(mode_q), .sel_q(sel_q),
    .rom_n(rom_n), .ram_n(ram_n), .en_n(en_n), .mode_n(mode_n), .sel_n(sel_n)
  );

  always_comb begin
    rom_d = rom_n & rom_mask;
    ram_d = ram_n & ram_mask;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rom_q  <= ROM_RST;
      ram_q  <= '0;
      en_q   <= 1'b0;
      mode_q <= 1'b0;
      sel_q  <= '0;
    end else if (upd) begin
      rom_q  <= rom_d;
      ram_q  <= ram_d;
      en_q   <= en_n;
      mode_q <= mode_n;
      sel_q  <= sel_n;
    end
  end

  assign rom_bank    = rom_q;
  assign ram_bank    = ram_q;
  assign ram_en      = en_q;
  assign clk_reg_sel = sel_q[CSEL_W-2:0];
  assign clk_reg_vld = sel_q[CSEL_W-1];

  // R1: enable follows the low nibble key
  a_r1_ram_enable: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (upd && region == RG_EN) |=> (ram_en == ($past(wr_data[3:0]) == 4'hA)));

  // R2: zero never reaches the low ROM field unless trimmed away
  a_r2_zero_remap: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (upd && kind == CT_TYPEA && (region == RG_ROM_A || region == RG_ROM_B)
     && wr_data[4:0] == 5'd0 && rom_mask[0]) |=> rom_bank[0]);

  // R6: clock-register valid bit follows data bit 3
  a_r6_clock_sel: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (upd && kind == CT_SEVEN && region == RG_AUX) |=> (clk_reg_vld == $past(wr_data[3])));

  // R8: bank numbers stay within fitted size after a write
  a_r8_rom_masked: assert property (@(posedge clk) disable iff (!rst_sync_n)
    upd |=> ((rom_bank & ~rom_mask) == '0));

  a_r8_ram_masked: assert property (@(posedge clk) disable iff (!rst_sync_n)
    upd |=> ((ram_bank & ~ram_mask) == '0));

  // R10: ignored cycles leave every output unchanged
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !upd |=> ($stable(rom_bank) && $stable(ram_bank) && $stable(ram_en)
              && $stable(clk_reg_sel) && $stable(clk_reg_vld)));

endmodule

// File: tb/cart_bank_ctrl_tb_top.sv
`timescale 1ns/1ps
module cart_bank_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  ctrl_type;
  logic [9:0]  rom_size;
  logic [4:0]  ram_size;
  logic        wr_en;
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;
  logic [8:0]  rom_bank;
  logic [3:0]  ram_bank;
  logic        ram_en;
  logic [2:0]  clk_reg_sel;
  logic        clk_reg_vld;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  int m_rom, m_ram, m_en, m_mode, m_sel;

  always #2.5 clk = ~clk;

  cart_bank_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_type(ctrl_type), .rom_size(rom_size),
    .ram_size(ram_size), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rom_bank(rom_bank), .ram_bank(ram_bank), .ram_en(ram_en),
    .clk_reg_sel(clk_reg_sel), .clk_reg_vld(clk_reg_vld)
  );

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    summary();
  end

  task automatic chk_lit(string tag, int got, int exp);
    n_checks++;
    if (got != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic chk_model(string tag);
    n_checks++;
    if (int'(rom_bank) != m_rom || int'(ram_bank) != m_ram || int'(ram_en) != m_en ||
        int'(clk_reg_sel) != (m_sel & 7) || int'(clk_reg_vld) != ((m_sel >> 3) & 1)) begin
      n_errors++;
      $display("FAIL %s: actual rom=%0h ram=%0h en=%0d sel=%0h vld=%0d expected rom=%0h ram=%0h en=%0d sel=%0h vld=%0d",
               tag, rom_bank, ram_bank, ram_en, clk_reg_sel, clk_reg_vld,
               m_rom, m_ram, m_en, m_sel & 7, (m_sel >> 3) & 1);
    end
  endtask

  function automatic string tag_of(int a);
    int r;
    r = (a >> 12) & 7;
    if (((a >> 15) & 1) == 1 || ctrl_type == 2'd3) return "R10";
    if (r < 2) return "R1";
    case (ctrl_type)
      2'd0: return (r < 4) ? "R2" : (r < 6) ? "R3" : "R4";
      2'd1: return (r < 4) ? "R5" : (r < 6) ? "R6" : "R10";
      default: return (r < 6) ? "R7" : "R10";
    endcase
  endfunction

  task automatic model_write(int a, int d);
    int r, v;
    if (((a >> 15) & 1) == 1 || ctrl_type == 2'd3) return;
    r = (a >> 12) & 7;
    if (r < 2) m_en = ((d & 15) == 10) ? 1 : 0;
    else begin
      case (ctrl_type)
        2'd0: begin
          if (r < 4) begin
            v = d & 31; if (v == 0) v = 1;
            m_rom = (m_rom & 'h60) | v;
          end else if (r < 6) begin
            if (m_mode == 1) m_ram = d & 3;
            else m_rom = (m_rom & 'h1F) | ((d & 3) << 5);
          end else m_mode = d & 1;
        end
        2'd1: begin
          if (r < 4) begin
            v = d & 127; m_rom = (v == 0) ? 1 : v;
          end else if (r < 6) begin
            m_sel = d & 15; m_ram = d & 3;
          end
        end
        default: begin
          if (r == 2) m_rom = (m_rom & 'h100) | ((d == 0) ? 1 : d);
          else if (r == 3) m_rom = (m_rom & 'hFF) | ((d & 1) << 8);
          else if (r < 6) m_ram = d & 15;
        end
      endcase
    end
    m_rom = m_rom & (int'(rom_size) - 1);
    m_ram = m_ram & (int'(ram_size) - 1);
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic do_wr(int a, int d, string tag);
    wr_en = 1'b1; wr_addr = 16'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
    chk_model(tag);
  endtask

  task automatic idle_cycle(int a, string tag);
    wr_en = 1'b0; wr_addr = 16'(a); wr_data = 8'h0A;
    @(negedge clk);
    chk_model(tag);
  endtask

  task automatic restart(int t, int rs, int ms);
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0;
    ctrl_type = 2'(t); rom_size = 10'(rs); ram_size = 5'(ms);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_rom = 1; m_ram = 0; m_en = 0; m_mode = 0; m_sel = 0;
    chk_model("R9 reset state");
  endtask

  task automatic random_run(int n);
    int a, d;
    for (int i = 0; i < n; i++) begin
      a = $urandom_range(0, 32'h7FFF);
      if ($urandom_range(0, 7) == 0) a = a | 'h8000;
      d = $urandom_range(0, 255);
      if ($urandom_range(0, 5) == 0) d = d & 'h80;
      if ($urandom_range(0, 7) == 0) d = (d & 'hF0) | 'hA;
      do_wr(a, d, tag_of(a));
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    ctrl_type = 2'd0; rom_size = 10'd128; ram_size = 5'd4;

    // flavour 0
    restart(0, 128, 4);
    chk_lit("R9 rom_bank", int'(rom_bank), 1);
    do_wr('h2000, 'h00, "R2 zero to one");
    chk_lit("R2 zero to one", int'(rom_bank), 1);
    do_wr('h4000, 'h03, "R3 mode0 upper bits");
    chk_lit("R3 mode0 upper bits", int'(rom_bank), 'h61);
    do_wr('h3F00, 'h1F, "R2 keeps bits 6:5");
    chk_lit("R2 keeps bits 6:5", int'(rom_bank), 'h7F);
    do_wr('h6000, 'h01, "R4 mode set");
    do_wr('h5FFF, 'h02, "R3 mode1 ram bank");
    chk_lit("R3 mode1 ram bank", int'(ram_bank), 2);
    chk_lit("R3 mode1 rom kept", int'(rom_bank), 'h7F);
    do_wr('h0000, 'h0A, "R1 enable");
    chk_lit("R1 enable", int'(ram_en), 1);
    do_wr('h1FFF, 'h5A, "R1 enable high nibble ignored");
    do_wr('h1000, 'h0B, "R1 disable");
    chk_lit("R1 disable", int'(ram_en), 0);
    do_wr('h8000, 'h05, "R10 upper half ignored");
    idle_cycle('h2000, "R10 no strobe");
    do_wr('h7000, 'h00, "R4 mode clear");
    do_wr('h4000, 'h01, "R3 mode0 again");
    chk_lit("R3 mode0 again", int'(rom_bank), 'h3F);
    random_run(400);

    // flavour 0, tiny sizes: remap then trim in one write
    restart(0, 1, 1);
    do_wr('h2000, 'h00, "R8 remap then trim");
    chk_lit("R8 remap then trim", int'(rom_bank), 0);
    restart(0, 32, 2);
    do_wr('h4000, 'h03, "R8 upper bits trimmed");
    chk_lit("R8 upper bits trimmed", int'(rom_bank), 1);
    random_run(300);

    // flavour 1
    restart(1, 128, 4);
    do_wr('h2000, 'h80, "R5 zero to one");
    chk_lit("R5 zero to one", int'(rom_bank), 1);
    do_wr('h3FFF, 'h7F, "R5 full bank");
    do_wr('h4000, 'h0B, "R6 select and ram");
    chk_lit("R6 select valid", int'(clk_reg_vld), 1);
    chk_lit("R6 select index", int'(clk_reg_sel), 3);
    chk_lit("R6 ram bank", int'(ram_bank), 3);
    do_wr('h6000, 'h01, "R10 latch range no effect");
    random_run(400);
    restart(1, 16, 2);
    do_wr('h4000, 'h07, "R6 select with trimmed ram");
    chk_lit("R6 trimmed ram", int'(ram_bank), 1);
    random_run(300);

    // flavour 2
    restart(2, 512, 16);
    do_wr('h2000, 'h00, "R7 zero to one");
    do_wr('h3000, 'h01, "R7 bit 8 set");
    chk_lit("R7 bit 8 set", int'(rom_bank), 'h101);
    do_wr('h2FFF, 'h55, "R7 low byte");
    chk_lit("R7 low byte", int'(rom_bank), 'h155);
    do_wr('h3ABC, 'hFE, "R7 bit 8 clear");
    chk_lit("R7 bit 8 clear", int'(rom_bank), 'h055);
    do_wr('h4000, 'hAF, "R7 ram bank");
    chk_lit("R7 ram bank", int'(ram_bank), 15);
    do_wr('h1000, 'h0A, "R1 enable flavour 2");
    random_run(400);
    restart(2, 64, 2);
    random_run(300);

    // flavour 3: nothing changes
    restart(3, 128, 4);
    do_wr('h2000, 'h05, "R10 flavour 3 ignored");
    do_wr('h0000, 'h0A, "R10 flavour 3 enable ignored");
    chk_lit("R10 flavour 3 enable ignored", int'(ram_en), 0);
    random_run(100);

    summary();
  end

endmodule